// File: doc/BRIEF.md
# ADC Overrange and Processing Fault Aggregator

This block merges error indications from two clock domains into one diagnostic line and adds an event counter. In the fast capture domain, the converter's overrange bit arrives as two phase samples, one per capture clock edge. Each phase sample is registered once in the fast domain and then ORed with the other. Any hit sets a sticky flag. A two-flop synchronizer carries that flag into the slow processing domain. It is safe there because it is a single latched bit that only rises between clears.

In the slow domain, three local faults each set a sticky flag of their own: a sample-drop overrun from an inter-stage crossing, a filter overflow, and a watchdog timeout. Two registered outputs are formed from these flags. The diagnostic line is the OR of the synchronized overrange flag and all three local flags. The overflow line is the OR of the synchronized overrange flag and the filter-overflow flag only. An 8-bit counter counts saturation events and stops at its top value.

A single clear pulse in the slow domain does three things. It zeroes the counter and the local flags, and, through a synchronizer into the fast domain, it also clears the fast-domain flag. Both domains use active-low asynchronous resets.

Top module: `diag_fault_aggregator`

## Requirements
- R1: After reset, diag_o, ovf_any_o and sat_cnt_o are all zero.
- R2: A rise-phase overrange sample lasting one fast cycle drives both diag_o and ovf_any_o to 1 within six slow cycles.
- R3: A fall-phase overrange sample lasting one fast cycle drives both diag_o and ovf_any_o to 1 within six slow cycles.
- R4: Once the overrange flag is set, diag_o and ovf_any_o stay at 1 after the input returns low, until a clear.
- R5: An overrun pulse sets diag_o and holds it at 1. ovf_any_o stays 0.
- R6: A filter-overflow pulse sets both diag_o and ovf_any_o, and both hold.
- R7: A watchdog-timeout pulse sets diag_o and holds it. ovf_any_o stays 0.
- R8: sat_cnt_o increases by one on each slow clock edge at which sat_evt_i is 1, and it holds when sat_evt_i is 0.
- R9: sat_cnt_o stops at 255 and does not wrap.
- R10: A one-cycle clr_i pulse zeroes sat_cnt_o on the next edge. It clears every sticky flag, including the fast-domain overrange flag, so diag_o and ovf_any_o are back at 0 within eight slow cycles.
- R11: Two rules apply when clr_i coincides with other inputs. A fault input that is 1 in the same cycle as clr_i keeps its flag set. A saturation event in the same cycle as clr_i is lost, and the counter reads 0.
- R12: A local fault sampled at clock edge k appears on diag_o after edge k+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast capture-domain clock |
| rst_fast_ni | input | 1 | Fast-domain asynchronous reset, active low |
| or_rise_i | input | 1 | Overrange sample from the rising capture phase |
| or_fall_i | input | 1 | Overrange sample from the falling capture phase |
| clk_i | input | 1 | Slow processing-domain clock |
| rst_ni | input | 1 | Slow-domain asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the flags and the counter |
| overrun_i | input | 1 | Sample-drop overrun indication |
| filt_ovf_i | input | 1 | Filter overflow indication |
| wdog_to_i | input | 1 | Watchdog timeout indication |
| sat_evt_i | input | 1 | Saturation event, counted once per cycle |
| diag_o | output | 1 | Aggregate diagnostic line |
| ovf_any_o | output | 1 | Aggregate overflow line |
| sat_cnt_o | output | 8 | Saturating saturation-event count |

## Verification
Single-fast-cycle overrange pulses are applied on the rising phase alone and on the falling phase alone. This separates a lost phase sample from a working capture path. Each local fault is pulsed on its own, so the bench can see which outputs each one reaches: overrun and watchdog must stay off the overflow line, while filter overflow must set it. Counter bursts of five events and of three hundred events separate correct counting from wrap-around. A clear that coincides with a fault and a counted event shows the priority between clear and set.

// File: rtl/diag_pkg.sv
package diag_pkg;
  localparam int unsigned N_LOCAL = 3;

  typedef enum int unsigned {
    FLT_OVERRUN = 0,
    FLT_FILT    = 1,
    FLT_WDOG    = 2
  } local_flt_e;

  typedef logic [N_LOCAL-1:0] local_vec_t;

  // local faults that also count as an overflow
  localparam local_vec_t OVF_MASK = local_vec_t'(1) << FLT_FILT;
endpackage

// File: rtl/diag_bit_sync.sv
module diag_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/diag_or_capture.sv
module diag_or_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic clr_i,
  output logic sticky_o
);
  logic rise_q, fall_q, sticky_q;
  logic hit;

  // re-register both phase samples before combining
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_i;
      fall_q <= fall_i;
    end
  end

  assign hit = rise_q | fall_q;

  // set wins over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_q <= 1'b0;
    else if (hit)    sticky_q <= 1'b1;
    else if (clr_i)  sticky_q <= 1'b0;
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/diag_sticky_bank.sv
module diag_sticky_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i)     flag_q <= 1'b0;
    end
    assign q_o[g] = flag_q;
  end
endmodule

// File: rtl/diag_sat_counter.sv
module diag_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/diag_fault_aggregator.sv
module diag_fault_aggregator #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_fast_i,
  input  logic             rst_fast_ni,
  input  logic             or_rise_i,
  input  logic             or_fall_i,
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             overrun_i,
  input  logic             filt_ovf_i,
  input  logic             wdog_to_i,
  input  logic             sat_evt_i,
  output logic             diag_o,
  output logic             ovf_any_o,
  output logic [CNT_W-1:0] sat_cnt_o
);
  import diag_pkg::*;

  logic       clr_fast;
  logic       or_sticky_fast;
  logic       or_sync;
  local_vec_t local_set, local_flag;
  logic       diag_q, ovf_q;

  // slow clear into fast domain
  diag_bit_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_fast_ni),
    .d_i    (clr_i),
    .q_o    (clr_fast)
  );

  diag_or_capture u_or_cap (
    .clk_i    (clk_fast_i),
    .rst_ni   (rst_fast_ni),
    .rise_i   (or_rise_i),
    .fall_i   (or_fall_i),
    .clr_i    (clr_fast),
    .sticky_o (or_sticky_fast)
  );

  // single latched bit: plain two-flop crossing is sufficient
  diag_bit_sync #(.STAGES(SYNC_STAGES)) u_or_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (or_sticky_fast),
    .q_o    (or_sync)
  );

  always_comb begin
    local_set              = '0;
    local_set[FLT_OVERRUN] = overrun_i;
    local_set[FLT_FILT]    = filt_ovf_i;
    local_set[FLT_WDOG]    = wdog_to_i;
  end

  diag_sticky_bank #(.N(N_LOCAL)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (local_set),
    .clr_i  (clr_i),
    .q_o    (local_flag)
  );

  diag_sat_counter #(.W(CNT_W)) u_sat_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sat_evt_i),
    .clr_i  (clr_i),
    .cnt_o  (sat_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      diag_q <= or_sync | (|local_flag);
      ovf_q  <= or_sync | (|(local_flag & OVF_MASK));
    end
  end

  assign diag_o    = diag_q;
  assign ovf_any_o = ovf_q;
endmodule

// File: rtl/diag_fault_aggregator_chk.sv
module diag_fault_aggregator_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             overrun_i,
  input logic             wdog_to_i,
  input logic             sat_evt_i,
  input logic             or_sync_i,
  input logic             diag_o,
  input logic             ovf_any_o,
  input logic [CNT_W-1:0] sat_cnt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R8
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && sat_evt_i && sat_cnt_o != TOP) |=> sat_cnt_o == $past(sat_cnt_o) + 1'b1);

  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !sat_evt_i) |=> $stable(sat_cnt_o));

  // R9
  cnt_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && sat_cnt_o == TOP) |=> sat_cnt_o == TOP);

  // R10
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sat_cnt_o == '0);

  // R12
  local_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i || wdog_to_i) |=> ##1 diag_o);

  // R2
  or_reach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    or_sync_i |=> (ovf_any_o && diag_o));
endmodule

bind diag_fault_aggregator diag_fault_aggregator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .overrun_i (overrun_i),
  .wdog_to_i (wdog_to_i),
  .sat_evt_i (sat_evt_i),
  .or_sync_i (or_sync),
  .diag_o    (diag_o),
  .ovf_any_o (ovf_any_o),
  .sat_cnt_o (sat_cnt_o)
);

// File: tb/tb_diag_fault_aggregator.sv
`timescale 1ns/1ps
module tb_diag_fault_aggregator;
  logic clk_fast = 1'b0, clk = 1'b0;
  logic rst_fast_n = 1'b0, rst_n = 1'b0;
  logic or_rise = 1'b0, or_fall = 1'b0;
  logic clr = 1'b0, overrun = 1'b0, filt_ovf = 1'b0, wdog_to = 1'b0, sat_evt = 1'b0;
  logic diag, ovf_any;
  logic [7:0] sat_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #1 clk_fast = ~clk_fast;
  always #2 clk = ~clk;

  diag_fault_aggregator dut (
    .clk_fast_i (clk_fast), .rst_fast_ni (rst_fast_n),
    .or_rise_i (or_rise), .or_fall_i (or_fall),
    .clk_i (clk), .rst_ni (rst_n), .clr_i (clr),
    .overrun_i (overrun), .filt_ovf_i (filt_ovf), .wdog_to_i (wdog_to),
    .sat_evt_i (sat_evt), .diag_o (diag), .ovf_any_o (ovf_any), .sat_cnt_o (sat_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic slow_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    slow_wait(8);
  endtask

  task automatic t_reset();
    check("R1 diag", diag, 0);
    check("R1 ovf", ovf_any, 0);
    check("R1 cnt", sat_cnt, 0);
  endtask

  task automatic t_rise();
    @(negedge clk_fast) or_rise = 1'b1;
    @(negedge clk_fast) or_rise = 1'b0;
    slow_wait(6);
    check("R2 diag", diag, 1);
    check("R2 ovf", ovf_any, 1);
    slow_wait(10);
    check("R4 diag held", diag, 1);
    check("R4 ovf held", ovf_any, 1);
    do_clear();
    check("R10 diag after clear", diag, 0);
    check("R10 ovf after clear", ovf_any, 0);
  endtask

  task automatic t_fall();
    @(negedge clk_fast) or_fall = 1'b1;
    @(negedge clk_fast) or_fall = 1'b0;
    slow_wait(6);
    check("R3 diag", diag, 1);
    check("R3 ovf", ovf_any, 1);
    do_clear();
    check("R10 diag after clear", diag, 0);
  endtask

  task automatic t_overrun();
    @(negedge clk) overrun = 1'b1;
    @(negedge clk) overrun = 1'b0;
    check("R12 not yet", diag, 0);
    @(negedge clk);
    check("R12 diag", diag, 1);
    slow_wait(5);
    check("R5 diag held", diag, 1);
    check("R5 ovf", ovf_any, 0);
    do_clear();
    check("R10 diag after clear", diag, 0);
  endtask

  task automatic t_filt();
    @(negedge clk) filt_ovf = 1'b1;
    @(negedge clk) filt_ovf = 1'b0;
    slow_wait(4);
    check("R6 diag", diag, 1);
    check("R6 ovf", ovf_any, 1);
    do_clear();
    check("R10 ovf after clear", ovf_any, 0);
  endtask

  task automatic t_wdog();
    @(negedge clk) wdog_to = 1'b1;
    @(negedge clk) wdog_to = 1'b0;
    slow_wait(4);
    check("R7 diag", diag, 1);
    check("R7 ovf", ovf_any, 0);
    do_clear();
    check("R10 diag after clear", diag, 0);
  endtask

  task automatic t_count();
    @(negedge clk) sat_evt = 1'b1;
    slow_wait(5);
    sat_evt = 1'b0;
    check("R8 count", sat_cnt, 5);
    slow_wait(4);
    check("R8 hold", sat_cnt, 5);
  endtask

  task automatic t_saturate();
    @(negedge clk) sat_evt = 1'b1;
    slow_wait(300);
    check("R9 top", sat_cnt, 255);
    slow_wait(3);
    sat_evt = 1'b0;
    check("R9 no wrap", sat_cnt, 255);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R10 cnt cleared", sat_cnt, 0);
    slow_wait(8);
  endtask

  task automatic t_clear_race();
    @(negedge clk) sat_evt = 1'b1;
    slow_wait(3);
    overrun = 1'b1;
    clr = 1'b1;
    @(negedge clk);
    overrun = 1'b0;
    clr = 1'b0;
    sat_evt = 1'b0;
    check("R11 cnt clear wins", sat_cnt, 0);
    slow_wait(2);
    check("R11 flag set wins", diag, 1);
    do_clear();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    slow_wait(4);
    rst_fast_n = 1'b1;
    rst_n = 1'b1;
    slow_wait(2);
    t_reset();
    t_rise();
    t_fall();
    t_overrun();
    t_filt();
    t_wdog();
    t_count();
    do_clear();
    t_saturate();
    t_clear_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule